// File: doc/BRIEF.md
# Transmit Descriptor Ring Index Tracker

This block keeps the two indices of a circular transmit descriptor array used by a DMA-driven network MAC. Software owns the produce index, which marks the first descriptor it has not yet handed to hardware. The block owns the consume index, which names the descriptor the transmit engine should fetch next. A single write port carries both software registers: a produce-index register and a ring-size register. The ring-size register holds the number of descriptors minus one. Each time the transmit engine finishes a frame it pulses a completion strobe, and the consume index steps forward by one.

The block derives the ring status from the two indices. The ring is empty when the indices are equal, and the engine is then told to stop. The ring is full when one more produced descriptor would catch up with the consume index. The block gives a one-cycle pulse on every completed frame and another one-cycle pulse when a completion drains the ring. A completion that arrives on an empty ring is dropped and recorded in a sticky error flag.

Top module: `tx_ring_index`

## Requirements
- R1: After reset both indices are 0, the ring-size register holds all ones (2^IDX_W descriptors), the ring reads empty and not full, txReady is low, and both pulses and the error flag are low.
- R2: A frame completion on a non-empty ring raises the consume index by exactly one in the following cycle. This holds from the very first completion after reset, so the first completion moves the index from 0 to 1.
- R3: A completion taken while the consume index equals the ring-size register sets the index to 0. The completion after that moves it from 0 to 1.
- R4: The ring is empty, and txReady is low, exactly when the two indices are equal. A completion strobe on an empty ring leaves the consume index unchanged and sets the sticky error flag.
- R5: A write with wrSel=0 loads the produce index from wrData in the next cycle when the ring is not full and wrData does not exceed the ring-size register.
- R6: The ring reads full when the produce index, advanced by one with wrap at the ring-size register, equals the consume index. A produce write while full is ignored.
- R7: A produce write whose value exceeds the ring-size register is ignored.
- R8: A write with wrSel=1 loads the ring-size register and clears both indices and the error flag in the next cycle. It takes precedence over a completion in the same cycle, which is then dropped with no pulse.
- R9: doneIrq is high for exactly the one cycle after each accepted completion.
- R10: emptyIrq is high for the one cycle after an accepted completion that leaves the consume index equal to the produce index as updated in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 produce index, 1 ring-size register |
| wrData | input | IDX_W | Write value |
| frameDone | input | 1 | One-cycle pulse from the transmit engine per finished frame |
| consumeIdx | output | IDX_W | Next descriptor to fetch |
| produceIdx | output | IDX_W | Current produce index |
| ringLast | output | IDX_W | Ring-size register (descriptor count minus one) |
| ringEmpty | output | 1 | Indices equal |
| ringFull | output | 1 | One more produced descriptor would fill the ring |
| txReady | output | 1 | Descriptors pending; engine may transmit |
| doneIrq | output | 1 | Pulse per accepted completion |
| emptyIrq | output | 1 | Pulse when a completion drains the ring |
| underflowErr | output | 1 | Sticky: completion seen on an empty ring |

## Verification
A consume index that steps by two, or that wraps at the wrong value, shows on consumeIdx in the cycle after the completion. It also shows later as txReady dropping early or late, against a produce index the bench has set. A wrong full or range decision shows as produceIdx moving, or failing to move, one cycle after a write. A wrong empty decision shows at once on txReady, and then as a missing or stray underflowErr or emptyIrq in the next cycle. Each completion in the bench is followed by a port comparison in the next cycle, so a fault is caught within one cycle of the stimulus that exposes it.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic advCons;
    logic loadProd;
    logic loadLast;
  } ringCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic empty;
    logic full;
    logic wrInRange;
    logic hitsOldProd;
    logic hitsNewProd;
  } ringStat_t;

endpackage

// File: rtl/tx_ring_dp.sv
module tx_ring_dp
  import tx_ring_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ringCtl_t         ctl,
  input  logic [IDX_W-1:0] wrData,
  output ringStat_t        stat,
  output logic [IDX_W-1:0] consumeIdx,
  output logic [IDX_W-1:0] produceIdx,
  output logic [IDX_W-1:0] ringLast
);
  localparam logic [IDX_W-1:0] LAST_INIT = '1;
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  logic [IDX_W-1:0] consQ, prodQ, lastQ;
  logic [IDX_W-1:0] consNext, prodNext;

  always_comb begin
    consNext = (consQ == lastQ) ? '0 : consQ + ONE;
    prodNext = (prodQ == lastQ) ? '0 : prodQ + ONE;
    stat.empty       = (consQ == prodQ);
    stat.full        = (prodNext == consQ);
    stat.wrInRange   = (wrData <= lastQ);
    stat.hitsOldProd = (consNext == prodQ);
    stat.hitsNewProd = (consNext == wrData);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      consQ <= '0;
      prodQ <= '0;
      lastQ <= LAST_INIT;
    end else if (ctl.loadLast) begin
      lastQ <= wrData;
      consQ <= '0;
      prodQ <= '0;
    end else begin
      if (ctl.advCons)  consQ <= consNext;
      if (ctl.loadProd) prodQ <= wrData;
    end
  end

  assign consumeIdx = consQ;
  assign produceIdx = prodQ;
  assign ringLast   = lastQ;
endmodule

// File: rtl/tx_ring_ctl.sv
module tx_ring_ctl
  import tx_ring_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic      wrSel,
  input  logic      frameDone,
  input  ringStat_t stat,
  output ringCtl_t  ctl,
  output logic      doneIrq,
  output logic      emptyIrq,
  output logic      underflowErr
);
  logic drained;

  always_comb begin
    ctl.loadLast = wrEn && wrSel;
    ctl.advCons  = frameDone && !stat.empty && !ctl.loadLast;
    ctl.loadProd = wrEn && !wrSel && !stat.full && stat.wrInRange;
    drained      = ctl.loadProd ? stat.hitsNewProd : stat.hitsOldProd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneIrq      <= 1'b0;
      emptyIrq     <= 1'b0;
      underflowErr <= 1'b0;
    end else begin
      doneIrq  <= ctl.advCons;
      emptyIrq <= ctl.advCons && drained;
      if (ctl.loadLast)
        underflowErr <= 1'b0;
      else if (frameDone && stat.empty)
        underflowErr <= 1'b1;
    end
  end
endmodule

// File: rtl/tx_ring_index.sv
module tx_ring_index #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [IDX_W-1:0] wrData,
  input  logic             frameDone,
  output logic [IDX_W-1:0] consumeIdx,
  output logic [IDX_W-1:0] produceIdx,
  output logic [IDX_W-1:0] ringLast,
  output logic             ringEmpty,
  output logic             ringFull,
  output logic             txReady,
  output logic             doneIrq,
  output logic             emptyIrq,
  output logic             underflowErr
);
  import tx_ring_pkg::*;

  ringCtl_t  ctlS;
  ringStat_t statS;

  tx_ring_ctl uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .frameDone(frameDone), .stat(statS), .ctl(ctlS),
    .doneIrq(doneIrq), .emptyIrq(emptyIrq), .underflowErr(underflowErr)
  );

  tx_ring_dp #(.IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctlS), .wrData(wrData), .stat(statS),
    .consumeIdx(consumeIdx), .produceIdx(produceIdx), .ringLast(ringLast)
  );

  assign ringEmpty = statS.empty;
  assign ringFull  = statS.full;
  assign txReady   = !statS.empty;
endmodule

// File: rtl/tx_ring_chk.sv
module tx_ring_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             wrSel,
  input logic [IDX_W-1:0] wrData,
  input logic             frameDone,
  input logic [IDX_W-1:0] consumeIdx,
  input logic [IDX_W-1:0] produceIdx,
  input logic [IDX_W-1:0] ringLast,
  input logic             ringEmpty,
  input logic             ringFull,
  input logic             doneIrq,
  input logic             underflowErr
);
  a_r2_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !ringEmpty && !(wrEn && wrSel) && consumeIdx != ringLast)
      |=> consumeIdx == $past(consumeIdx) + IDX_W'(1));

  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !ringEmpty && !(wrEn && wrSel) && consumeIdx == ringLast)
      |=> consumeIdx == '0);

  a_r4_empty_hold: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && ringEmpty && !(wrEn && wrSel))
      |=> $stable(consumeIdx) && underflowErr);

  a_r6_full_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel && ringFull) |=> $stable(produceIdx));

  a_r7_range_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel && wrData > ringLast) |=> $stable(produceIdx));

  a_r8_size_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel) |=> consumeIdx == '0 && produceIdx == '0 && !underflowErr && !doneIrq);

  a_r9_done_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneIrq) |-> $past(frameDone));
endmodule

bind tx_ring_index tx_ring_chk #(.IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .frameDone(frameDone), .consumeIdx(consumeIdx), .produceIdx(produceIdx),
  .ringLast(ringLast), .ringEmpty(ringEmpty), .ringFull(ringFull),
  .doneIrq(doneIrq), .underflowErr(underflowErr)
);

// File: tb/sim_tx_ring_index.sv
module sim_tx_ring_index;
  localparam int W = 4;

  typedef struct {
    string      tag;
    logic [W-1:0] cons, prod, last;
    logic       empty, full, ready, dIrq, eIrq, err;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, wrSel = 1'b0, frameDone = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] consumeIdx, produceIdx, ringLast;
  logic ringEmpty, ringFull, txReady, doneIrq, emptyIrq, underflowErr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  expItem_t expQ[$];

  logic [W-1:0] mLast, mProd, mCons;
  logic mErr;

  always #5 clk = ~clk;

  tx_ring_index #(.IDX_W(W)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .frameDone(frameDone), .consumeIdx(consumeIdx), .produceIdx(produceIdx),
    .ringLast(ringLast), .ringEmpty(ringEmpty), .ringFull(ringFull),
    .txReady(txReady), .doneIrq(doneIrq), .emptyIrq(emptyIrq),
    .underflowErr(underflowErr)
  );

  function automatic logic [W-1:0] nxt(input logic [W-1:0] i);
    return (i == mLast) ? '0 : i + W'(1);
  endfunction

  task automatic compare(input expItem_t e);
    checks++;
    if (consumeIdx !== e.cons || produceIdx !== e.prod || ringLast !== e.last ||
        ringEmpty !== e.empty || ringFull !== e.full || txReady !== e.ready ||
        doneIrq !== e.dIrq || emptyIrq !== e.eIrq || underflowErr !== e.err) begin
      failures++;
      $display("FAIL %s actual cons=%0d prod=%0d last=%0d emp=%b full=%b rdy=%b dI=%b eI=%b err=%b expected cons=%0d prod=%0d last=%0d emp=%b full=%b rdy=%b dI=%b eI=%b err=%b",
        e.tag, consumeIdx, produceIdx, ringLast, ringEmpty, ringFull, txReady,
        doneIrq, emptyIrq, underflowErr, e.cons, e.prod, e.last, e.empty,
        e.full, e.ready, e.dIrq, e.eIrq, e.err);
    end
  endtask

  // driver: one cycle of stimulus, model update, push expectation
  task automatic step(input logic we, input logic sel, input logic [W-1:0] d,
                      input logic fd, input string tag);
    expItem_t e;
    logic emp, fl, adv, ld;
    @(negedge clk);
    wrEn = we; wrSel = sel; wrData = d; frameDone = fd;
    emp = (mCons == mProd);
    fl  = (nxt(mProd) == mCons);
    e.dIrq = 1'b0; e.eIrq = 1'b0;
    if (we && sel) begin
      mLast = d; mProd = '0; mCons = '0; mErr = 1'b0;
    end else begin
      adv = fd && !emp;
      ld  = we && !fl && (d <= mLast);
      if (fd && emp) mErr = 1'b1;
      if (adv) mCons = nxt(mCons);
      if (ld)  mProd = d;
      e.dIrq = adv;
      e.eIrq = adv && (mCons == mProd);
    end
    e.tag = tag; e.cons = mCons; e.prod = mProd; e.last = mLast;
    e.empty = (mCons == mProd); e.full = (nxt(mProd) == mCons);
    e.ready = !e.empty; e.err = mErr;
    expQ.push_back(e);
  endtask

  // monitor: after each edge, pop and compare
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) compare(expQ.pop_front());
    end
  end

  initial begin
    expItem_t r;
    mLast = '1; mProd = '0; mCons = '0; mErr = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    r.tag = "R1 reset"; r.cons = '0; r.prod = '0; r.last = '1; r.empty = 1'b1;
    r.full = 1'b0; r.ready = 1'b0; r.dIrq = 1'b0; r.eIrq = 1'b0; r.err = 1'b0;
    compare(r);
    @(negedge clk); rstN = 1'b1;

    step(1, 1, 4'd3, 0, "R8 size=4");
    step(1, 0, 4'd3, 0, "R5 produce 3");
    step(1, 0, 4'd1, 0, "R6 write while full");
    step(0, 0, 4'd0, 1, "R2 first frame 0->1");
    step(0, 0, 4'd0, 0, "R9 pulse clears");
    step(0, 0, 4'd0, 1, "R2 frame 1->2");
    step(0, 0, 4'd0, 1, "R10 frame drains");
    step(0, 0, 4'd0, 1, "R4 frame on empty");
    step(1, 0, 4'd5, 0, "R7 out of range");
    step(1, 0, 4'd1, 0, "R5 produce 1");
    step(0, 0, 4'd0, 1, "R3 wrap 3->0");
    step(0, 0, 4'd0, 1, "R3 after wrap 0->1");
    step(1, 0, 4'd3, 0, "R5 produce 3");
    step(1, 1, 4'd7, 1, "R8 size with frame");
    step(1, 0, 4'd2, 0, "R5 produce 2");
    step(1, 0, 4'd4, 1, "R10 frame with write");
    step(0, 0, 4'd0, 1, "R2 frame 1->2");
    step(0, 0, 4'd0, 0, "R9 idle");
    step(0, 0, 4'd0, 0, "R9 idle");
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule